// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a few general-purpose inputs and raises one interrupt line when a selected input makes a selected transition. Two byte-wide enable registers control it. One enables interrupts on high-to-low changes and the other on low-to-high changes. Neither register has a plain write. Each one has a set alias and a clear alias on a simple synchronous register bus. A 1 in the data written to the set alias turns the matching enable on. A 1 written to the clear alias turns it off. Either alias reads back the register.

Each input is synchronized and compared with its value one clock earlier. An edge whose enable is on latches a sticky per-input pending flag. The interrupt output is high while any pending flag is set. Software reads the flags at a status address and clears them by writing 1s there. An edge that arrives in the same cycle as the clear keeps its flag set.

Top module: `gpio_edge_irq`

## Requirements
- R1: The falling-edge enable register is set through address 0x1C and cleared through address 0x1D.
- R2: The rising-edge enable register is set through address 0x1E and cleared through address 0x1F.
- R3: A write to a set alias makes the register equal to its old value ORed with the write data. Bits written as 0 keep their value.
- R4: A write to a clear alias clears each register bit where the write data is 1. Bits written as 0 keep their value.
- R5: A read of either alias of a pair returns that register. Starting from 0x28, a set write of 0x88 gives 0xA8, and a following clear write of 0x88 gives 0x20.
- R6: Bit n of each enable register belongs to input n for n below the input count. The remaining bits up to bit 7 are plain storage that can be read, set and cleared and has no effect on interrupts.
- R7: An input change is seen on the third rising clock edge after it is applied. If the edge's enable bit is 1, that clock edge sets the pending flag of the input. The flag stays set until it is cleared. `irq` is 1 exactly when any pending flag is 1.
- R8: An edge whose enable bit is 0 sets no pending flag.
- R9: The pending flags read at address 0x20, with bit n for input n and the upper bits 0. Writing a 1 to a bit there clears that flag. If a new enabled edge is detected in the same cycle, the flag stays set.
- R10: Reset clears both enable registers and all pending flags. Inputs that are high during reset produce no edge when reset is released. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| gpio_in | input | 3 | Asynchronous general-purpose inputs |
| irq | output | 1 | Interrupt, the OR of all pending flags |

## Verification
The bench builds the block with its default parameters: three inputs, byte-wide registers and a two-stage synchronizer. With these values, enable bits 3 to 7 are storage only, so writes that touch only those bits must leave the interrupt unaffected (R6). The two-stage chain plus the history flop gives a fixed three-edge latency. Because of that fixed latency, a status-clear write can be timed to land on exactly the cycle in which a new edge is latched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // Kind of access a bus write makes to one aliased enable register
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_SET  = 2'd1,
      ACC_CLR  = 2'd2
   } alias_acc_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int N_IN   = 3,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] d,
   output logic [N_IN-1:0] q,
   output logic [N_IN-1:0] q_prev
);
   localparam int DEPTH = STAGES + 1;

   logic [N_IN-1:0] chain [DEPTH];

   // During reset every stage tracks the live level, so release shows no edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) chain[i] <= d;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      end
   end

   assign q      = chain[STAGES-1];
   assign q_prev = chain[STAGES];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
   parameter int N_IN  = 3,
   parameter int REG_W = 8
) (
   input  logic [N_IN-1:0]  cur,
   input  logic [N_IN-1:0]  prev,
   input  logic [N_IN-1:0]  fall_en,
   input  logic [N_IN-1:0]  rise_en,
   output logic [REG_W-1:0] hit
);
   genvar b;
   generate
      for (b = 0; b < REG_W; b++) begin : g_bit
         if (b < N_IN) begin : g_live
            assign hit[b] = (prev[b] & ~cur[b] & fall_en[b]) |
                            (~prev[b] & cur[b] & rise_en[b]);
         end else begin : g_none
            assign hit[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_alias_mask.sv
module gpio_alias_mask
   import gpio_irq_pkg::*;
#(
   parameter int          REG_W    = 8,
   parameter int          ADDR_W   = 8,
   parameter logic [7:0]  SET_ADDR = 8'h1C,
   parameter logic [7:0]  CLR_ADDR = 8'h1D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  mask
);
   alias_acc_e acc;

   always_comb begin
      acc = ACC_NONE;
      if (we && addr == ADDR_W'(SET_ADDR)) acc = ACC_SET;
      else if (we && addr == ADDR_W'(CLR_ADDR)) acc = ACC_CLR;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mask <= '0;
      else begin
         case (acc)
            ACC_SET: mask <= mask | wdata;
            ACC_CLR: mask <= mask & ~wdata;
            default: mask <= mask;
         endcase
      end
   end

   AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_SET) |=> ((mask & $past(mask)) == $past(mask)
                            && (mask & $past(wdata)) == $past(wdata))) // R3
      else $error("set alias lost or missed a bit");
   AST_CLR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_CLR) |=> ((mask & ~$past(mask)) == '0
                            && (mask & $past(wdata)) == '0)) // R4
      else $error("clear alias raised or kept a bit");
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_NONE) |=> $stable(mask)) // R1
      else $error("enable register moved without an alias write");
endmodule

// File: rtl/gpio_pend_flags.sv
module gpio_pend_flags #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] hit,
   input  logic             clr_we,
   input  logic [REG_W-1:0] clr_data,
   output logic [REG_W-1:0] pend
);
   logic [REG_W-1:0] clr_vec;

   assign clr_vec = clr_we ? clr_data : '0;

   // A fresh hit wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_vec) | hit;
   end

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((pend & $past(pend)) == $past(pend))) // R7
      else $error("pending flag dropped without a clear");
   AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend)) != '0) |-> ((pend & ~$past(pend) & ~$past(hit)) == '0)) // R8
      else $error("pending flag rose without an enabled edge");
   AST_CLR_WINS_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((pend & $past(clr_data) & ~$past(hit)) == '0)) // R9
      else $error("status clear failed");
   AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((pend & $past(hit)) == $past(hit))) // R9
      else $error("edge lost against clear");
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int         N_IN        = 3,
   parameter int         REG_W       = 8,
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] FALL_SET    = 8'h1C,
   parameter logic [7:0] FALL_CLR    = 8'h1D,
   parameter logic [7:0] RISE_SET    = 8'h1E,
   parameter logic [7:0] RISE_CLR    = 8'h1F,
   parameter logic [7:0] STAT_ADDR   = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              bus_we,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [N_IN-1:0]   gpio_in,
   output logic              irq
);
   generate
      if (N_IN < 1 || N_IN > REG_W) begin : g_bad_width
         $error("N_IN must lie between 1 and REG_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [N_IN-1:0]  lvl, lvl_prev;
   logic [REG_W-1:0] fall_mask, rise_mask, hit, pend;
   logic             stat_we;

   gpio_sync #(.N_IN(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(lvl), .q_prev(lvl_prev));

   gpio_alias_mask #(.REG_W(REG_W), .ADDR_W(ADDR_W),
                     .SET_ADDR(FALL_SET), .CLR_ADDR(FALL_CLR)) u_fall (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
      .wdata(bus_wdata), .mask(fall_mask));

   gpio_alias_mask #(.REG_W(REG_W), .ADDR_W(ADDR_W),
                     .SET_ADDR(RISE_SET), .CLR_ADDR(RISE_CLR)) u_rise (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
      .wdata(bus_wdata), .mask(rise_mask));

   gpio_edge_detect #(.N_IN(N_IN), .REG_W(REG_W)) u_edge (
      .cur(lvl), .prev(lvl_prev),
      .fall_en(fall_mask[N_IN-1:0]), .rise_en(rise_mask[N_IN-1:0]),
      .hit(hit));

   assign stat_we = bus_we && (bus_addr == ADDR_W'(STAT_ADDR));

   gpio_pend_flags #(.REG_W(REG_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .hit(hit),
      .clr_we(stat_we), .clr_data(bus_wdata), .pend(pend));

   always_comb begin
      if (bus_addr == ADDR_W'(FALL_SET) || bus_addr == ADDR_W'(FALL_CLR))
         bus_rdata = fall_mask;
      else if (bus_addr == ADDR_W'(RISE_SET) || bus_addr == ADDR_W'(RISE_CLR))
         bus_rdata = rise_mask;
      else if (bus_addr == ADDR_W'(STAT_ADDR))
         bus_rdata = pend;
      else
         bus_rdata = '0;
   end

   assign irq = |pend;

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !stat_we) |=> irq) // R7
      else $error("interrupt dropped without a status clear");
   AST_NO_EDGE_AT_RELEASE: assert property (@(posedge clk)
      $rose(rst_n) |-> (hit == '0)) // R10
      else $error("edge seen at reset release");
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb_top;
   localparam int N = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic [N-1:0] gpio_in = 3'b101;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   // Reference state, plain integers
   int m_s1, m_s2, m_prev, m_fall, m_rise, m_pend;

   always #5 clk = ~clk;

   gpio_edge_irq dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .gpio_in(gpio_in), .irq(irq));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_read(input int a);
      if (a == 'h1C || a == 'h1D) return m_fall;
      if (a == 'h1E || a == 'h1F) return m_rise;
      if (a == 'h20) return m_pend;
      return 0;
   endfunction

   // Reference model advanced on each clock edge
   always @(posedge clk) begin
      int g, hit, clr;
      g = int'(gpio_in);
      if (!rst_n) begin
         m_s1 = g; m_s2 = g; m_prev = g;
         m_fall = 0; m_rise = 0; m_pend = 0;
      end else begin
         hit = ((m_prev & ~m_s2 & m_fall) | (~m_prev & m_s2 & m_rise)) & 7;
         clr = (bus_we && bus_addr == 8'h20) ? int'(bus_wdata) : 0;
         m_pend = (m_pend & ~clr) | hit;
         if (bus_we && bus_addr == 8'h1C) m_fall = m_fall | bus_wdata;
         if (bus_we && bus_addr == 8'h1D) m_fall = m_fall & ~int'(bus_wdata) & 255;
         if (bus_we && bus_addr == 8'h1E) m_rise = m_rise | bus_wdata;
         if (bus_we && bus_addr == 8'h1F) m_rise = m_rise & ~int'(bus_wdata) & 255;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = g;
      end
   end

   // Every-cycle comparison, half a period after the edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(irq == (m_pend != 0), "R7 irq", int'(irq), int'(m_pend != 0));
         chk(int'(bus_rdata) == exp_read(int'(bus_addr)), "R5 read",
             int'(bus_rdata), exp_read(int'(bus_addr)));
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input int exp, input string tag);
      @(negedge clk); bus_addr = a; #1;
      chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(5);
      // R10: inputs high during reset give nothing, registers zero
      chk(irq == 1'b0, "R10 irq after reset", int'(irq), 0);
      rd(8'h1C, 0, "R10 fall reset");
      rd(8'h1F, 0, "R10 rise reset");
      rd(8'h20, 0, "R10 status reset");
      rd(8'h33, 0, "R10 unmapped");
      // R5 worked example on the falling-edge register
      wr(8'h1C, 8'h28); rd(8'h1D, 'h28, "R1 fall set");
      wr(8'h1C, 8'h88); rd(8'h1C, 'hA8, "R3 set ORs");
      wr(8'h1D, 8'h88); rd(8'h1D, 'h20, "R4 clear");
      // R2 rising register through its own aliases
      wr(8'h1E, 8'hFF); rd(8'h1F, 'hFF, "R2 rise set");
      wr(8'h1F, 8'hF8); rd(8'h1E, 'h07, "R2 rise clear");
      rd(8'h1C, 'h20, "R2 fall untouched");
      // R8: falling edge on input 0 with its enable off
      gpio_in = 3'b100; idle(6);
      rd(8'h20, 0, "R8 disabled edge");
      // R6: upper storage bits set, still no interrupt on falling input 2
      wr(8'h1C, 8'hF8); gpio_in = 3'b000; idle(6);
      rd(8'h20, 0, "R6 upper bits inert");
      wr(8'h1D, 8'hF8);
      // R7: rising edge on input 1, third edge latency
      @(negedge clk); gpio_in = 3'b010;
      @(negedge clk); chk(irq == 1'b0, "R7 latency 1", int'(irq), 0);
      @(negedge clk); chk(irq == 1'b0, "R7 latency 2", int'(irq), 0);
      @(negedge clk); chk(irq == 1'b1, "R7 latency 3", int'(irq), 1);
      idle(4);
      rd(8'h20, 'h02, "R7 sticky");
      // R9: write-one-to-clear
      wr(8'h20, 8'h02); rd(8'h20, 0, "R9 clear");
      chk(irq == 1'b0, "R9 irq low", int'(irq), 0);
      // R9: clear lands on the edge that latches a new hit on input 0
      @(negedge clk); gpio_in = 3'b011;
      idle(2);
      bus_addr = 8'h20; bus_wdata = 8'h01; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
      rd(8'h20, 'h01, "R9 edge wins");
      wr(8'h20, 8'hFF);
      // Mixed random traffic checked by the model every cycle
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         bus_addr  = 8'h1C + 8'($urandom_range(0, 5));
         bus_wdata = 8'($urandom);
         bus_we    = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 2) == 0) gpio_in = 3'($urandom);
      end
      @(negedge clk); bus_we = 1'b0;
      idle(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule